// File: doc/BRIEF.md
# Multi-Channel Interrupt Latency Counter

This peripheral measures how long software takes to respond to an interrupt. Each of its channels watches one interrupt line. When the line triggers, the channel begins counting clock cycles. It keeps counting until software sets that channel's bit in a stop register. The count then freezes and the channel's valid flag rises. Software reads the frozen count and clears the stop bit, which returns the channel to idle so that it can measure again. A clock-frequency register lets software turn counts into time.

The channel count, the counter width, the counting clock frequency and the per-channel trigger mode are elaboration parameters. Bit i of `EDGE_MASK` set to 1 makes channel i edge-triggered; set to 0 it makes the channel level-triggered. Access is through a plain single-cycle register port. A write takes effect at the clock edge where `reg_we` is high. Read data is combinational from `reg_addr`. There is no handshake and no back-pressure: every access completes in the cycle it is presented.

Top module: `irq_latency_meter`

## Requirements
- R1: After reset the following all read 0: every count register, the stop register, the valid register and the enable bit. The read-only channel-count field and the frequency register keep their parameter values.
- R2: The control word is at byte address 0x80. Bit 0 is the global enable and can be read and written. Bits [6:2] are read-only and hold N_CH modulo 32. All other bits read 0. Address 0x84 reads CLK_HZ.
- R3: An edge-mode channel starts on a rising edge of its interrupt, but only while it is idle, enabled and its stop bit is 0. Its count sits zero-extended at byte address 4×channel.
- R4: A level-mode channel starts in any cycle where its interrupt is high while it is idle, enabled and its stop bit is 0.
- R5: Stop is at 0x88 and valid at 0x8C, one bit per channel, with bit i for channel i. Suppose a channel samples its trigger at clock edge k and a stop write is accepted at edge m. The count then freezes at m−k, and the valid bit reads 1 after edge m+1. The count stays stable while the stop bit remains set.
- R6: A trigger that arrives while a channel is counting or holding a valid result does not change its count.
- R7: Clearing a channel's stop bit while it is valid makes the valid bit read 0 and the count read 0 after the next edge. The channel can then start again, and a level-mode channel whose line is still high restarts one edge later.
- R8: A running count saturates at 2^CNT_W−1 and does not wrap.
- R9: While enable is 0, every channel is idle, its count and valid bit read 0, and no channel starts. Clearing enable during a measurement discards that measurement.
- R10: Stop and valid bits at or above N_CH read 0, and writes to them have no effect.
- R11: Any unaligned address, and any aligned address that maps to no register, reads 0. This includes count slots of channels that are not connected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_CH | Interrupt lines, one per channel, synchronous to clk |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
Two situations are hard to reach from the ports. The first is saturation, which needs a channel to run for more than 2^CNT_W cycles. The bench uses an 8-bit counter and holds a stop write back for 300 cycles to get there. The second is a level-mode channel restarting right after re-arm. This only happens when the line is still high at the moment the stop bit clears. The bench keeps one level line asserted through the whole stop/clear sequence, so the restart edge can be checked against the model. A behavioural model is stepped on every edge and compared with the read port on every cycle. This catches off-by-one slips at the start edge and the stop edge.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_RUN  = 2'd1,
    CH_DONE = 2'd2
  } ch_state_t;

  localparam logic [7:0] OFS_CTRL  = 8'h80;
  localparam logic [7:0] OFS_FREQ  = 8'h84;
  localparam logic [7:0] OFS_STOP  = 8'h88;
  localparam logic [7:0] OFS_VALID = 8'h8C;
  localparam int         MAX_CH    = 32;
endpackage

// File: rtl/ilc_channel.sv
module ilc_channel
  import ilc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter bit EDGE  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             irq_i,
  input  logic             stop_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  ch_state_t        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             trig;

  generate
    if (EDGE) begin : g_edge
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_i;
      end
      assign trig = irq_i & ~irq_q;
    end else begin : g_level
      assign trig = irq_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CH_IDLE;
      cnt_q <= '0;
    end else if (!en_i) begin
      st_q  <= CH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        CH_IDLE: begin
          if (trig && !stop_i) begin
            st_q  <= CH_RUN;
            cnt_q <= '0;
          end
        end
        CH_RUN: begin
          if (stop_i)              st_q  <= CH_DONE;
          else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        CH_DONE: begin
          if (!stop_i) begin
            st_q  <= CH_IDLE;
            cnt_q <= '0;
          end
        end
        default: begin
          st_q  <= CH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign valid_o = (st_q == CH_DONE);
  assign count_o = cnt_q;

  // R8: a saturated running count never wraps
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_RUN && cnt_q == CNT_MAX && en_i) |=> (count_o == CNT_MAX));

  // R5: a captured result is held while stop stays set
  p_done_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && stop_i && en_i) |=> (valid_o && $stable(count_o)));

  // R7: clearing stop drops valid and count at the next edge
  p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !stop_i) |=> (!valid_o && count_o == '0));

  // R9: disabled channel is idle and empty
  p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> (!valid_o && count_o == '0));
endmodule

// File: rtl/ilc_regs.sv
module ilc_regs
  import ilc_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int CLK_HZ = 100_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_we,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  en_o,
  output logic [N_CH-1:0]       stop_o,
  input  logic [N_CH-1:0]       valid_i,
  input  logic [N_CH*CNT_W-1:0] counts_i
);
  localparam int          CH_FIELD = N_CH % 32;
  localparam logic [31:0] FREQ_VAL = 32'(CLK_HZ);
  localparam logic [31:0] CH_MASK  = (N_CH >= 32) ? 32'hFFFF_FFFF
                                                  : ((32'd1 << N_CH) - 32'd1);

  logic            en_q;
  logic [N_CH-1:0] stop_q;
  logic [31:0]     cnt_rd;
  logic            cnt_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      stop_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_W'(OFS_CTRL)) en_q   <= reg_wdata[0];
      if (reg_addr == ADDR_W'(OFS_STOP)) stop_q <= reg_wdata[N_CH-1:0];
    end
  end

  always_comb begin
    cnt_rd  = '0;
    cnt_hit = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      if (reg_addr == ADDR_W'(i * 4)) begin
        cnt_hit = 1'b1;
        cnt_rd  = 32'(counts_i[i*CNT_W +: CNT_W]);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (cnt_hit) begin
      reg_rdata = cnt_rd;
    end else begin
      unique case (reg_addr)
        ADDR_W'(OFS_CTRL):  reg_rdata = {25'd0, 5'(CH_FIELD), 1'b0, en_q};
        ADDR_W'(OFS_FREQ):  reg_rdata = FREQ_VAL;
        ADDR_W'(OFS_STOP):  reg_rdata = 32'(stop_q);
        ADDR_W'(OFS_VALID): reg_rdata = 32'(valid_i);
        default:            reg_rdata = '0;
      endcase
    end
  end

  assign en_o   = en_q;
  assign stop_o = stop_q;

  // R10: bits of absent channels never read back as 1
  p_absent_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFS_STOP) || reg_addr == ADDR_W'(OFS_VALID))
      |-> ((reg_rdata & ~CH_MASK) == 32'd0));

  // R11: unaligned accesses read zero
  p_unaligned_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] != 2'b00) |-> (reg_rdata == 32'd0));

  // R2: enable bit follows the last control write
  p_enable_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(OFS_CTRL)) |=> (en_o == $past(reg_wdata[0])));
endmodule

// File: rtl/irq_latency_meter.sv
module irq_latency_meter
  import ilc_pkg::*;
#(
  parameter int            N_CH      = 8,
  parameter int            CNT_W     = 32,
  parameter int            ADDR_W    = 8,
  parameter int            CLK_HZ    = 100_000_000,
  parameter logic [31:0]   EDGE_MASK = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   irq_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  logic                  en;
  logic [N_CH-1:0]       stop;
  logic [N_CH-1:0]       valid;
  logic [N_CH*CNT_W-1:0] counts;

  ilc_regs #(
    .N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CLK_HZ(CLK_HZ)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .en_o(en), .stop_o(stop), .valid_i(valid), .counts_i(counts)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    ilc_channel #(.CNT_W(CNT_W), .EDGE(EDGE_MASK[g])) u_ch (
      .clk(clk), .rst_n(rst_n), .en_i(en), .irq_i(irq_i[g]),
      .stop_i(stop[g]), .valid_o(valid[g]),
      .count_o(counts[g*CNT_W +: CNT_W])
    );
  end

  // R5: a valid bit can only be up if its stop bit was set at the prior edge
  p_valid_needs_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid & ~$past(stop)) == '0));

  // R9: enable low at an edge leaves no valid result behind
  p_no_valid_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (valid == '0));
endmodule

// File: tb/test_irq_latency_meter.sv
module test_irq_latency_meter;
  localparam int          N      = 4;
  localparam int          CW     = 8;
  localparam int          CLK_HZ = 100_000_000;
  localparam logic [31:0] EMASK  = 32'h5;
  localparam int          CMAX   = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic [7:0]  addr = 8'h00;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_latency_meter #(
    .N_CH(N), .CNT_W(CW), .ADDR_W(8), .CLK_HZ(CLK_HZ), .EDGE_MASK(EMASK)
  ) i_irq_latency_meter (
    .clk(clk), .rst_n(rst_n), .irq_i(irq),
    .reg_addr(addr), .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata)
  );

  // behavioural model: 0 idle, 1 counting, 2 holding result
  int           m_st  [N];
  int           m_cnt [N];
  bit           m_prev[N];
  bit           m_en;
  bit [N-1:0]   m_stop;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_st[i] = 0; m_cnt[i] = 0; m_prev[i] = 0;
      end
      m_en = 0; m_stop = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit t;
        t = EMASK[i] ? (irq[i] && !m_prev[i]) : irq[i];
        if (!m_en) begin
          m_st[i] = 0; m_cnt[i] = 0;
        end else if (m_st[i] == 0) begin
          if (t && !m_stop[i]) begin m_st[i] = 1; m_cnt[i] = 0; end
        end else if (m_st[i] == 1) begin
          if (m_stop[i]) m_st[i] = 2;
          else if (m_cnt[i] < CMAX) m_cnt[i] = m_cnt[i] + 1;
        end else begin
          if (!m_stop[i]) begin m_st[i] = 0; m_cnt[i] = 0; end
        end
        m_prev[i] = irq[i];
      end
      if (we && addr == 8'h80) m_en = wdata[0];
      if (we && addr == 8'h88) m_stop = wdata[N-1:0];
    end
  end

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    logic [31:0] v;
    v = '0;
    if (a[1:0] != 2'b00) return '0;
    if (a < 8'(N * 4)) return 32'(m_cnt[a >> 2]);
    case (a)
      8'h80: v = 32'((N % 32) << 2) | 32'(m_en);
      8'h84: v = 32'(CLK_HZ);
      8'h88: v = 32'(m_stop);
      8'h8C: for (int i = 0; i < N; i++) v[i] = (m_st[i] == 2);
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string req_of(input logic [7:0] a);
    if (a[1:0] != 2'b00) return "R11";
    if (a < 8'(N * 4)) return "R3";
    if (a == 8'h80 || a == 8'h84) return "R2";
    if (a == 8'h88 || a == 8'h8C) return "R5";
    return "R11";
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // lockstep comparison on every clock
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) check(req_of(addr), rdata, model_rd(addr));
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h80, v); check("R1", v, 32'h10);
    rd(8'h84, v); check("R1", v, CLK_HZ);
    rd(8'h00, v); check("R1", v, 0);
    rd(8'h88, v); check("R1", v, 0);
    rd(8'h8C, v); check("R1", v, 0);
    // R9 no start while disabled
    @(negedge clk); irq[0] = 1'b1; irq[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h00, v); check("R9", v, 0);
    rd(8'h04, v); check("R9", v, 0);
    @(negedge clk); irq[0] = 1'b0; irq[1] = 1'b0;
    // R2 enable
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, v); check("R2", v, 32'h11);
    // R3/R5 edge channel 0: stop accepted 10 edges after start
    @(negedge clk); irq[0] = 1'b1;
    repeat (9) @(negedge clk);
    wr(8'h88, 32'h1);
    rd(8'h00, v); check("R5", v, 10);
    rd(8'h8C, v); check("R5", v, 32'h1);
    // R6 retrigger while holding result
    @(negedge clk); irq[0] = 1'b0;
    @(negedge clk); irq[0] = 1'b1;
    repeat (3) @(negedge clk);
    rd(8'h00, v); check("R6", v, 10);
    // R4 level channel 1
    @(negedge clk); irq[1] = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'h88, 32'h3);
    rd(8'h04, v); check("R4", v, 5);
    rd(8'h8C, v); check("R4", v, 32'h3);
    // R7 re-arm, level channel 1 restarts with line still high
    wr(8'h88, 32'h0);
    rd(8'h8C, v); check("R7", v, 0);
    rd(8'h00, v); check("R7", v, 0);
    rd(8'h04, v); check("R7", v, 1);
    @(negedge clk); irq[1] = 1'b0;
    // R8 saturation on edge channel 2
    @(negedge clk); irq[2] = 1'b1;
    repeat (300) @(negedge clk);
    wr(8'h88, 32'h6);
    rd(8'h08, v); check("R8", v, CMAX);
    rd(8'h04, v); check("R8", v, CMAX);
    rd(8'h8C, v); check("R8", v, 32'h6);
    // R9 disable during a measurement on level channel 3
    @(negedge clk); irq[3] = 1'b1;
    repeat (5) @(negedge clk);
    wr(8'h80, 32'h0);
    rd(8'h0C, v); check("R9", v, 0);
    rd(8'h8C, v); check("R9", v, 0);
    rd(8'h08, v); check("R9", v, 0);
    // R10 absent-channel bits
    wr(8'h88, 32'hFFFF_FFF0);
    rd(8'h88, v); check("R10", v, 0);
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h88, v); check("R10", v, 32'hF);
    // R11 unmapped
    rd(8'h10, v); check("R11", v, 0);
    rd(8'h90, v); check("R11", v, 0);
    rd(8'h82, v); check("R11", v, 0);
    rd(8'hFC, v); check("R11", v, 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule